// File: doc/BRIEF.md
# Segment-Triggered Barrier and Broadcast Fetch Unit

This unit sits in front of the local memories of a group of processing elements (PEs). Each PE presents read requests carrying an address and a kind bit that marks the request as an instruction fetch or a data fetch. The top address bit selects the segment. Requests to the private segment are acknowledged on the next cycle, and each PE proceeds on its own. Requests to the shared segment are held with wait states.

A shared-segment access is how a PE arrives at a barrier. Once every PE whose enable bit is set has arrived, the unit releases all of them on one common clock edge. If any arrival was an instruction fetch, the word at the head of an internal broadcast queue is handed to every released PE and removed from the queue. If every arrival was a data fetch, the barrier is a pure synchronization point: the returned word is zero and the queue is left untouched.

The enable mask is written through a small write port. A write is accepted only while no PE is waiting at the barrier. Broadcast words are loaded through a push port.

Top module: `sync_fetch_hub`

## Requirements
- R1: A request whose address has its top bit at 0 (private segment) gets `rsp_ready` for that PE exactly one cycle after it is first presented, whatever the other PEs are doing.
- R2: A request with the top address bit at 1 (shared segment) gets no `rsp_ready` while any enabled PE has not yet made a shared-segment request.
- R3: The barrier completes on the cycle after the last enabled PE arrives, and all enabled PEs see `rsp_ready` on that same cycle.
- R4: When at least one arrival was an instruction fetch (`req_insn`=1), the release carries the oldest queued word on `rsp_data` and removes it, so successive releases return words in push order.
- R5: When every arrival was a data fetch, the release puts 0 on `rsp_data` and leaves the queue unchanged.
- R6: An instruction-fetch barrier that completes while the queue is empty is held until a word is pushed, and is released on the second cycle after that push.
- R7: A shared-segment request from a PE whose enable bit is 0 stays stalled with no `rsp_ready` and does not count toward completion.
- R8: A write to the enable mask is ignored while any PE is waiting at the barrier.
- R9: A request is ignored in the cycle its `rsp_ready` is high, so a PE that keeps requesting the shared segment arrives again one cycle after its release.
- R10: A push while the queue holds `Q_DEPTH` words is dropped, and `bq_full` stays high.
- R11: After reset, `rsp_ready` and `rsp_data` are 0, the queue is empty and the enable mask is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PE | Request present, one bit per PE, held until acknowledged |
| req_addr | input | NUM_PE*ADDR_W | Request addresses, PE i in slice i |
| req_insn | input | NUM_PE | 1 = instruction fetch, 0 = data fetch |
| rsp_ready | output | NUM_PE | One-cycle acknowledge per PE |
| rsp_data | output | DATA_W | Word returned by the most recent barrier release |
| mask_wr | input | 1 | Enable mask write strobe |
| mask_wdata | input | NUM_PE | New enable mask |
| mask_q | output | NUM_PE | Current enable mask |
| bq_push | input | 1 | Push a broadcast word |
| bq_wdata | input | DATA_W | Broadcast word to push |
| bq_full | output | 1 | Broadcast queue full |
| bq_empty | output | 1 | Broadcast queue empty |

## Verification
The bench staggers arrivals so that a unit that released on a partial count, or released PEs on different edges, shows an early or split acknowledge. It mixes data-fetch and instruction-fetch barriers around a known queue: a unit that popped on a data barrier returns the wrong word at the next instruction barrier, and one that released on an empty queue shows an acknowledge with stale data. It tries a mask write during a pending barrier, which a faulty unit would accept and so release a lone PE early. It holds requests across a release to catch a double acknowledge, and overfills the queue to catch a push that overwrites data instead of being dropped.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_INSN = 1'b1
  } fetch_kind_e;

  function automatic logic next_is_wrap(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1);
  endfunction

endpackage

// File: rtl/sfh_seg_decode.sv
module sfh_seg_decode #(
  parameter int NUM_PE = 16,
  parameter int ADDR_W = 16
) (
  input  logic [NUM_PE-1:0]        req_valid,
  input  logic [NUM_PE*ADDR_W-1:0] req_addr,
  input  logic [NUM_PE-1:0]        ack_now,
  output logic [NUM_PE-1:0]        priv_req,
  output logic [NUM_PE-1:0]        shr_req
);

  localparam int SEG_BIT = ADDR_W - 1;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    logic seg_hi;
    logic live;
    assign seg_hi      = req_addr[g*ADDR_W + SEG_BIT];
    assign live        = req_valid[g] && !ack_now[g];
    assign priv_req[g] = live && !seg_hi;
    assign shr_req[g]  = live && seg_hi;
  end

endmodule

// File: rtl/sfh_arrival.sv
module sfh_arrival #(
  parameter int NUM_PE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PE-1:0] shr_req,
  input  logic [NUM_PE-1:0] req_insn,
  input  logic              fire,
  input  logic              mask_wr,
  input  logic [NUM_PE-1:0] mask_wdata,
  output logic [NUM_PE-1:0] arrived,
  output logic [NUM_PE-1:0] arr_insn,
  output logic [NUM_PE-1:0] mask,
  output logic              pending
);

  assign pending = |arrived;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
    end else if (mask_wr && !pending) begin
      mask <= mask_wdata;
    end
  end

  for (genvar g = 0; g < NUM_PE; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        arrived[g]  <= 1'b0;
        arr_insn[g] <= 1'b0;
      end else if (fire) begin
        arrived[g]  <= 1'b0;
        arr_insn[g] <= 1'b0;
      end else if (shr_req[g] && mask[g] && !arrived[g]) begin
        arrived[g]  <= 1'b1;
        arr_insn[g] <= req_insn[g];
      end
    end
  end

endmodule

// File: rtl/sfh_bcast_fifo.sv
module sfh_bcast_fifo #(
  parameter int DATA_W  = 32,
  parameter int Q_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty
);

  localparam int PTR_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int CNT_W = $clog2(Q_DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(Q_DEPTH);

  logic [DATA_W-1:0] mem [Q_DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) begin
        wptr <= sfh_pkg::next_is_wrap(int'(wptr), Q_DEPTH) ? '0 : wptr + 1'b1;
      end
      if (do_pop) begin
        rptr <= sfh_pkg::next_is_wrap(int'(rptr), Q_DEPTH) ? '0 : rptr + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sfh_release.sv
module sfh_release #(
  parameter int NUM_PE = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_PE-1:0] arrived,
  input  logic [NUM_PE-1:0] arr_insn,
  input  logic [NUM_PE-1:0] mask,
  input  logic [NUM_PE-1:0] priv_req,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  output logic              fire,
  output logic              pop,
  output logic [NUM_PE-1:0] rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);

  import sfh_pkg::*;

  logic        all_in;
  fetch_kind_e kind;

  assign all_in = (mask != '0) && ((arrived & mask) == mask);
  assign kind   = (|(arrived & arr_insn)) ? KIND_INSN : KIND_DATA;
  assign fire   = all_in && ((kind == KIND_DATA) || !q_empty);
  assign pop    = fire && (kind == KIND_INSN);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_ready <= priv_req | (fire ? mask : '0);
      if (fire) begin
        rsp_data <= (kind == KIND_INSN) ? q_head : '0;
      end
    end
  end

endmodule

// File: rtl/sync_fetch_hub.sv
module sync_fetch_hub #(
  parameter int NUM_PE  = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int Q_DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PE-1:0]        req_valid,
  input  logic [NUM_PE*ADDR_W-1:0] req_addr,
  input  logic [NUM_PE-1:0]        req_insn,
  output logic [NUM_PE-1:0]        rsp_ready,
  output logic [DATA_W-1:0]        rsp_data,
  input  logic                     mask_wr,
  input  logic [NUM_PE-1:0]        mask_wdata,
  output logic [NUM_PE-1:0]        mask_q,
  input  logic                     bq_push,
  input  logic [DATA_W-1:0]        bq_wdata,
  output logic                     bq_full,
  output logic                     bq_empty
);

  logic [NUM_PE-1:0] priv_req, shr_req;
  logic [NUM_PE-1:0] arr_vec, arr_insn;
  logic              rel_fire, rel_pop, bar_pending;
  logic [DATA_W-1:0] q_head;

  sfh_seg_decode #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .ack_now   (rsp_ready),
    .priv_req  (priv_req),
    .shr_req   (shr_req)
  );

  sfh_arrival #(.NUM_PE(NUM_PE)) u_arr (
    .clk        (clk),
    .rst        (rst),
    .shr_req    (shr_req),
    .req_insn   (req_insn),
    .fire       (rel_fire),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .arrived    (arr_vec),
    .arr_insn   (arr_insn),
    .mask       (mask_q),
    .pending    (bar_pending)
  );

  sfh_bcast_fifo #(.DATA_W(DATA_W), .Q_DEPTH(Q_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (bq_push),
    .wdata (bq_wdata),
    .pop   (rel_pop),
    .head  (q_head),
    .full  (bq_full),
    .empty (bq_empty)
  );

  sfh_release #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) u_rel (
    .clk       (clk),
    .rst       (rst),
    .arrived   (arr_vec),
    .arr_insn  (arr_insn),
    .mask      (mask_q),
    .priv_req  (priv_req),
    .q_empty   (bq_empty),
    .q_head    (q_head),
    .fire      (rel_fire),
    .pop       (rel_pop),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

endmodule

// File: rtl/sfh_checker.sv
module sfh_checker #(
  parameter int NUM_PE = 16,
  parameter int ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_PE-1:0]        req_valid,
  input logic [NUM_PE*ADDR_W-1:0] req_addr,
  input logic [NUM_PE-1:0]        rsp_ready,
  input logic [NUM_PE-1:0]        mask_q,
  input logic                     bq_full,
  input logic                     bq_empty,
  input logic                     fire,
  input logic                     pop,
  input logic [NUM_PE-1:0]        arrived
);

  for (genvar g = 0; g < NUM_PE; g++) begin : g_priv
    AST_PRIV_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (req_valid[g] && !req_addr[g*ADDR_W + ADDR_W - 1] && !rsp_ready[g]) |=> rsp_ready[g]); // R1
  end

  AST_FIRE_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
    fire |-> ((mask_q != '0) && ((arrived & mask_q) == mask_q))); // R2

  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((rsp_ready & mask_q) == mask_q)); // R3

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !bq_empty); // R6

  AST_DISABLED_NO_ARRIVAL: assert property (@(posedge clk) disable iff (rst)
    (arrived & ~mask_q) == '0); // R7

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (|arrived) |=> $stable(mask_q)); // R8

  AST_CLEAR_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    fire |=> (arrived == '0)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(bq_full && bq_empty)); // R10

endmodule

bind sync_fetch_hub sfh_checker #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .rsp_ready (rsp_ready),
  .mask_q    (mask_q),
  .bq_full   (bq_full),
  .bq_empty  (bq_empty),
  .fire      (rel_fire),
  .pop       (rel_pop),
  .arrived   (arr_vec)
);

// File: tb/sync_fetch_hub_tb.sv
module sync_fetch_hub_tb;

  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int QD = 4;
  localparam logic [NP-1:0] ALL = '1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    req_valid = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP-1:0]    req_insn = '0;
  logic [NP-1:0]    rsp_ready;
  logic [DW-1:0]    rsp_data;
  logic             mask_wr = 1'b0;
  logic [NP-1:0]    mask_wdata = '0;
  logic [NP-1:0]    mask_q;
  logic             bq_push = 1'b0;
  logic [DW-1:0]    bq_wdata = '0;
  logic             bq_full, bq_empty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_fetch_hub #(.NUM_PE(NP), .ADDR_W(AW), .DATA_W(DW), .Q_DEPTH(QD)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_insn(req_insn), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_q(mask_q),
    .bq_push(bq_push), .bq_wdata(bq_wdata), .bq_full(bq_full), .bq_empty(bq_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_req(input int pe, input bit shared, input bit insn);
    req_valid[pe] = 1'b1;
    req_addr[pe*AW +: AW] = shared ? 8'h84 : 8'h10;
    req_insn[pe] = insn;
  endtask

  task automatic clr_req(input int pe);
    req_valid[pe] = 1'b0;
    req_insn[pe] = 1'b0;
  endtask

  task automatic push_word(input logic [DW-1:0] w);
    bq_push = 1'b1;
    bq_wdata = w;
    @(negedge clk);
    bq_push = 1'b0;
  endtask

  task automatic barrier(input logic [NP-1:0] who, input logic [NP-1:0] insn,
                         input logic [DW-1:0] exp_data, input string tag);
    for (int i = 0; i < NP; i++) if (who[i]) set_req(i, 1'b1, insn[i]);
    @(negedge clk);
    chk({tag, " wait"}, 32'(rsp_ready), 32'h0);
    @(negedge clk);
    chk({tag, " ready"}, 32'(rsp_ready), 32'(ALL));
    chk({tag, " data"}, 32'(rsp_data), 32'(exp_data));
    for (int i = 0; i < NP; i++) if (who[i]) clr_req(i);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 ready", 32'(rsp_ready), 32'h0);
    chk("R11 data", 32'(rsp_data), 32'h0);
    chk("R11 empty", 32'(bq_empty), 32'h1);
    chk("R11 full", 32'(bq_full), 32'h0);
    chk("R11 mask", 32'(mask_q), 32'(ALL));
  endtask

  task automatic t_private();
    set_req(0, 1'b0, 1'b1);
    set_req(3, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 two private", 32'(rsp_ready), 32'h9);
    clr_req(0);
    clr_req(3);
    set_req(1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 single private", 32'(rsp_ready), 32'h2);
    clr_req(1);
    @(negedge clk);
    chk("R1 no repeat", 32'(rsp_ready), 32'h0);
  endtask

  task automatic t_stagger();
    for (int p = 0; p < NP - 1; p++) begin
      set_req(p, 1'b1, 1'b0);
      repeat (2) begin
        @(negedge clk);
        chk("R2 partial stall", 32'(rsp_ready), 32'h0);
      end
    end
    set_req(NP - 1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R3 one cycle after last", 32'(rsp_ready), 32'h0);
    @(negedge clk);
    chk("R3 common release", 32'(rsp_ready), 32'(ALL));
    chk("R5 data barrier word", 32'(rsp_data), 32'h0);
    for (int p = 0; p < NP; p++) clr_req(p);
    @(negedge clk);
  endtask

  task automatic t_order();
    push_word(16'hA001);
    push_word(16'hB002);
    push_word(16'hC003);
    barrier(ALL, ALL, 16'hA001, "R4 first insn");
    barrier(ALL, '0, 16'h0000, "R5 data no pop");
    barrier(ALL, ALL, 16'hB002, "R5 head kept");
    barrier(ALL, 4'b0100, 16'hC003, "R4 mixed kind");
    chk("R4 drained", 32'(bq_empty), 32'h1);
  endtask

  task automatic t_empty_hold();
    for (int p = 0; p < NP; p++) set_req(p, 1'b1, 1'b1);
    repeat (5) begin
      @(negedge clk);
      chk("R6 held on empty", 32'(rsp_ready), 32'h0);
    end
    bq_push = 1'b1;
    bq_wdata = 16'hD004;
    @(negedge clk);
    bq_push = 1'b0;
    chk("R6 not yet", 32'(rsp_ready), 32'h0);
    @(negedge clk);
    chk("R6 released", 32'(rsp_ready), 32'(ALL));
    chk("R6 word", 32'(rsp_data), 32'hD004);
    for (int p = 0; p < NP; p++) clr_req(p);
    @(negedge clk);
  endtask

  task automatic t_disabled();
    mask_wr = 1'b1;
    mask_wdata = 4'b0111;
    @(negedge clk);
    mask_wr = 1'b0;
    chk("R7 mask written", 32'(mask_q), 32'h7);
    for (int p = 0; p < NP; p++) set_req(p, 1'b1, 1'b0);
    @(negedge clk);
    chk("R7 wait", 32'(rsp_ready), 32'h0);
    @(negedge clk);
    chk("R7 enabled only", 32'(rsp_ready), 32'h7);
    for (int p = 0; p < NP - 1; p++) clr_req(p);
    repeat (3) begin
      @(negedge clk);
      chk("R7 disabled stalls", 32'(rsp_ready), 32'h0);
    end
    clr_req(NP - 1);
    mask_wr = 1'b1;
    mask_wdata = ALL;
    @(negedge clk);
    mask_wr = 1'b0;
    chk("R7 mask restored", 32'(mask_q), 32'(ALL));
  endtask

  task automatic t_mask_locked();
    set_req(0, 1'b1, 1'b0);
    @(negedge clk);
    mask_wr = 1'b1;
    mask_wdata = 4'b0001;
    @(negedge clk);
    mask_wr = 1'b0;
    chk("R8 mask unchanged", 32'(mask_q), 32'(ALL));
    repeat (2) begin
      @(negedge clk);
      chk("R8 lone PE waits", 32'(rsp_ready), 32'h0);
    end
    for (int p = 1; p < NP; p++) set_req(p, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 wait", 32'(rsp_ready), 32'h0);
    @(negedge clk);
    chk("R8 full release", 32'(rsp_ready), 32'(ALL));
    for (int p = 0; p < NP; p++) clr_req(p);
    @(negedge clk);
  endtask

  task automatic t_rearrive();
    logic [NP-1:0] pat [6];
    pat = '{4'h0, ALL, 4'h0, 4'h0, ALL, 4'h0};
    for (int p = 0; p < NP; p++) set_req(p, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R9 held request pattern", 32'(rsp_ready), 32'(pat[k]));
      if (k == 4) for (int p = 0; p < NP; p++) clr_req(p);
    end
  endtask

  task automatic t_full();
    for (int k = 0; k < QD; k++) push_word(16'hE000 + 16'(k));
    chk("R10 full flag", 32'(bq_full), 32'h1);
    push_word(16'hFFFF);
    chk("R10 still full", 32'(bq_full), 32'h1);
    for (int k = 0; k < QD; k++) barrier(ALL, ALL, 16'hE000 + 16'(k), "R4 fifo order");
    chk("R10 empty after drain", 32'(bq_empty), 32'h1);
    for (int p = 0; p < NP; p++) set_req(p, 1'b1, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk("R10 dropped push", 32'(rsp_ready), 32'h0);
    end
    push_word(16'h1234);
    @(negedge clk);
    chk("R10 late release", 32'(rsp_ready), 32'(ALL));
    chk("R10 late word", 32'(rsp_data), 32'h1234);
    for (int p = 0; p < NP; p++) clr_req(p);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_private();
    t_stagger();
    t_order();
    t_empty_hold();
    t_disabled();
    t_mask_locked();
    t_rearrive();
    t_full();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule